// File: doc/BRIEF.md
# Downstream Bus Reset Sequencer

This block brings up an external bus that the host controller drives. After a start pulse it walks a small set of control outputs through a fixed order. First the reset driver and the clock driver are enabled while the bus clock is still stopped and the bus reset is still asserted. Next the bus clock is started. Reset is then held for a timed interval and released. After that the internal arbiter is selected. A short arbitration wait and a long settling wait follow, and then the block raises a ready flag.

Every wait is counted in clock cycles. The counts come from a clock-frequency parameter given in kHz and are rounded up, so each wait lasts at least its nominal time. The ready flag stays high until the next start pulse, and that pulse runs the whole sequence again. A start pulse that arrives while the sequence is running has no effect.

Top module: `rst_seq_top`

## Requirements
- R1: While reset is asserted, and after reset until a start pulse is taken, all six outputs are low.
- R2: In the cycle after a start is taken, `bus_rst_oe` and `bus_clk_oe` are high while `bus_clk_run`, `bus_rst_release`, `arb_internal` and `bus_ready` are low. Both output enables then stay high for the rest of the sequence.
- R3: `bus_clk_run` rises exactly one cycle after the output enables, while `bus_rst_release` is still low.
- R4: `bus_rst_release` rises exactly NH cycles after `bus_clk_run`, where NH = ceil(HOLD_US*CLK_KHZ/1000). The default HOLD_US is 150.
- R5: `arb_internal` rises exactly one cycle after `bus_rst_release`. The enables, the clock and the release all stay high.
- R6: `bus_ready` rises exactly NA+NS cycles after `arb_internal`. NA is ceil(ARB_US*CLK_KHZ/1000), with a default ARB_US of 1. NS is ceil(SETTLE_US*CLK_KHZ/1000), with a default SETTLE_US of 10000.
- R7: Each wait count is rounded up from the parameters and is never less than one cycle.
- R8: A start pulse taken while the sequence is running is ignored: the output timeline continues unchanged.
- R9: `bus_ready` stays high until a new start pulse. A start taken while ready restarts the sequence at the R2 step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled on the rising clock edge |
| bus_rst_oe | output | 1 | Output enable of the bus reset driver |
| bus_clk_oe | output | 1 | Output enable of the bus clock driver |
| bus_clk_run | output | 1 | Bus clock running |
| bus_rst_release | output | 1 | Bus reset released (deasserted) |
| arb_internal | output | 1 | Internal arbiter selected |
| bus_ready | output | 1 | Sequence complete, bus ready |

## Verification
Let E0 be the clock edge that takes a start pulse. Every output is registered, so the enables are due just after E0 and `bus_clk_run` one edge later. `bus_rst_release` is due NH edges after that, `arb_internal` one edge after the release, and `bus_ready` NA+NS edges after the arbiter select. The bench computes these edge indices from the parameters by ceiling division. It samples every output on the falling edge after each rising edge, comparing against the index j counted from E0. Injected start pulses and restarts are driven on the falling edge, so it is clear which rising edge captures each one.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRIVE,
        ST_HOLD,
        ST_RELEASE,
        ST_ARB,
        ST_SETTLE,
        ST_READY
    } seq_state_e;

    typedef struct packed {
        logic rst_oe;
        logic clk_oe;
        logic clk_run;
        logic rst_rel;
        logic arb_int;
        logic ready;
    } bus_ctl_t;

    // Microseconds to clock cycles, rounded up, never below one cycle.
    function automatic longint us_to_cycles(input longint us, input longint khz);
        longint c;
        c = (us * khz + 64'sd999) / 64'sd1000;
        if (c < 64'sd1) c = 64'sd1;
        return c;
    endfunction

    function automatic longint max3(input longint a, input longint b, input longint c);
        longint m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rst_seq_timer.sv
module rst_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int W          = 8,
    parameter int HOLD_CYC   = 4,
    parameter int ARB_CYC    = 1,
    parameter int SETTLE_CYC = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         tmr_expired,
    output logic         tmr_load,
    output logic [W-1:0] tmr_val,
    output bus_ctl_t     ctl
);
    localparam logic [W-1:0] HOLD_LD   = W'(HOLD_CYC - 1);
    localparam logic [W-1:0] ARB_LD    = W'(ARB_CYC - 1);
    localparam logic [W-1:0] SETTLE_LD = W'(SETTLE_CYC - 1);

    typedef struct packed {
        seq_state_e st;
        bus_ctl_t   ctl;
    } seq_reg_t;

    seq_reg_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.st)
            ST_IDLE, ST_READY: begin
                if (start) begin
                    r_d.st          = ST_DRIVE;
                    r_d.ctl         = '0;
                    r_d.ctl.rst_oe  = 1'b1;
                    r_d.ctl.clk_oe  = 1'b1;
                end
            end
            ST_DRIVE: begin
                r_d.st          = ST_HOLD;
                r_d.ctl.clk_run = 1'b1;
                tmr_load        = 1'b1;
                tmr_val         = HOLD_LD;
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    r_d.st          = ST_RELEASE;
                    r_d.ctl.rst_rel = 1'b1;
                end
            end
            ST_RELEASE: begin
                r_d.st          = ST_ARB;
                r_d.ctl.arb_int = 1'b1;
                tmr_load        = 1'b1;
                tmr_val         = ARB_LD;
            end
            ST_ARB: begin
                if (tmr_expired) begin
                    r_d.st   = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = SETTLE_LD;
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) begin
                    r_d.st        = ST_READY;
                    r_d.ctl.ready = 1'b1;
                end
            end
            default: begin
                r_d.st  = ST_IDLE;
                r_d.ctl = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.ctl <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctl = r_q.ctl;
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
    import rst_seq_pkg::*;
#(
    parameter int CLK_KHZ   = 125000,
    parameter int HOLD_US   = 150,
    parameter int ARB_US    = 1,
    parameter int SETTLE_US = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic bus_rst_oe,
    output logic bus_clk_oe,
    output logic bus_clk_run,
    output logic bus_rst_release,
    output logic arb_internal,
    output logic bus_ready
);
    localparam int HOLD_CYC   = int'(us_to_cycles(longint'(HOLD_US),   longint'(CLK_KHZ)));
    localparam int ARB_CYC    = int'(us_to_cycles(longint'(ARB_US),    longint'(CLK_KHZ)));
    localparam int SETTLE_CYC = int'(us_to_cycles(longint'(SETTLE_US), longint'(CLK_KHZ)));
    localparam int CNT_MAX    = int'(max3(longint'(HOLD_CYC), longint'(ARB_CYC), longint'(SETTLE_CYC)));
    localparam int CNT_W      = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    bus_ctl_t         ctl;

    rst_seq_fsm #(
        .W          (CNT_W),
        .HOLD_CYC   (HOLD_CYC),
        .ARB_CYC    (ARB_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .ctl         (ctl)
    );

    rst_seq_timer #(
        .W (CNT_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    assign bus_rst_oe      = ctl.rst_oe;
    assign bus_clk_oe      = ctl.clk_oe;
    assign bus_clk_run     = ctl.clk_run;
    assign bus_rst_release = ctl.rst_rel;
    assign arb_internal    = ctl.arb_int;
    assign bus_ready       = ctl.ready;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
    parameter int HOLD_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic bus_rst_oe,
    input logic bus_clk_oe,
    input logic bus_clk_run,
    input logic bus_rst_release,
    input logic arb_internal,
    input logic bus_ready
);
    int unsigned hold_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           hold_cnt <= 0;
        else if (!bus_clk_run)                hold_cnt <= 0;
        else if (!bus_rst_release)            hold_cnt <= hold_cnt + 1;
    end

    // R2: drivers are enabled while the clock is still stopped
    p_oe_before_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_clk_oe) |-> !bus_clk_run && !bus_rst_release);

    // R3: clock only runs with both drivers enabled
    p_clk_needs_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_clk_run |-> bus_clk_oe && bus_rst_oe);

    // R4: release only with clock running, after exactly the hold count
    p_rel_needs_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_release |-> bus_clk_run);
    p_hold_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rst_release) |-> hold_cnt == HOLD_CYC);

    // R5: arbiter select follows release by one cycle
    p_arb_after_rel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rst_release) |=> arb_internal);
    p_arb_needs_rel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arb_internal |-> bus_rst_release);

    // R6: ready only with the arbiter selected
    p_ready_needs_arb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> arb_internal);

    // R8: a running sequence keeps its clock on whatever start does
    p_run_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_clk_run && !bus_ready |=> bus_clk_run);

    // R9: ready holds until a new start
    p_ready_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready && !start |=> bus_ready);
endmodule

bind rst_seq_top rst_seq_chk #(
    .HOLD_CYC (HOLD_CYC)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start           (start),
    .bus_rst_oe      (bus_rst_oe),
    .bus_clk_oe      (bus_clk_oe),
    .bus_clk_run     (bus_clk_run),
    .bus_rst_release (bus_rst_release),
    .arb_internal    (arb_internal),
    .bus_ready       (bus_ready)
);

// File: tb/sim_rst_seq_top.sv
`timescale 1ns/1ps
module sim_rst_seq_top;
    localparam int KHZ   = 2500;
    localparam int H_US  = 150;
    localparam int A_US  = 1;
    localparam int S_US  = 10000;

    function automatic int ceil_cyc(input int us);
        longint p;
        p = longint'(us) * longint'(KHZ);
        return (p % 1000 == 0) ? int'(p / 1000) : int'(p / 1000) + 1;
    endfunction

    localparam int NH = 375;     // 150 us * 2.5 MHz, exact
    localparam int NA = 3;       // 1 us * 2.5 MHz = 2.5, rounded up
    localparam int NS = 25000;   // 10 ms * 2.5 MHz

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic bus_rst_oe, bus_clk_oe, bus_clk_run, bus_rst_release, arb_internal, bus_ready;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    rst_seq_top #(
        .CLK_KHZ   (KHZ),
        .HOLD_US   (H_US),
        .ARB_US    (A_US),
        .SETTLE_US (S_US)
    ) u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .start           (start),
        .bus_rst_oe      (bus_rst_oe),
        .bus_clk_oe      (bus_clk_oe),
        .bus_clk_run     (bus_clk_run),
        .bus_rst_release (bus_rst_release),
        .arb_internal    (arb_internal),
        .bus_ready       (bus_ready)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int done_idx();
        return 2 + ceil_cyc(H_US) + ceil_cyc(A_US) + ceil_cyc(S_US);
    endfunction

    // Expected outputs j rising edges after the edge that took the start.
    task automatic check_at(input int j);
        int d;
        d = done_idx();
        chk("R2", "rst_oe",  bus_rst_oe,      1);
        chk("R2", "clk_oe",  bus_clk_oe,      1);
        chk("R3", "clk_run", bus_clk_run,     (j >= 1) ? 1 : 0);
        chk("R4", "release", bus_rst_release, (j >= 1 + ceil_cyc(H_US)) ? 1 : 0);
        chk("R5", "arb",     arb_internal,    (j >= 2 + ceil_cyc(H_US)) ? 1 : 0);
        chk("R6", "ready",   bus_ready,       (j >= d) ? 1 : 0);
    endtask

    task automatic check_idle(input string req);
        chk(req, "all outputs low",
            {bus_rst_oe, bus_clk_oe, bus_clk_run, bus_rst_release, arb_internal, bus_ready}, 0);
    endtask

    // Run one sequence from a start pulse; optional ignored pulses and early abort.
    task automatic run_seq(input bit inject, input int abort_at);
        int d, rel_first, arb_first, rdy_first;
        d = done_idx();
        rel_first = -1; arb_first = -1; rdy_first = -1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j <= d + 20; j++) begin
            check_at(j);
            if (bus_rst_release && rel_first < 0) rel_first = j;
            if (arb_internal && arb_first < 0) arb_first = j;
            if (bus_ready && rdy_first < 0) rdy_first = j;
            if (abort_at >= 0 && j == abort_at) begin
                rst_n = 1'b0;
                #1;
                check_idle("R1");
                @(negedge clk);
                check_idle("R1");
                rst_n = 1'b1;
                return;
            end
            if (inject && j < d - 2 && ($urandom % 53) == 0) start = 1'b1; // R8 pulse
            else if (inject && (j == 0 || j == NH || j == d - 3)) start = 1'b1; // R8 corners
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        chk("R7", "hold span",   rel_first - 1, NH);
        chk("R7", "arb+settle",  rdy_first - arb_first, NA + NS);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        #1;
        check_idle("R1");
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        repeat (5 + ($urandom % 7)) @(negedge clk);
        check_idle("R1");
        chk("R7", "hold count",   ceil_cyc(H_US), NH);
        chk("R7", "arb count",    ceil_cyc(A_US), NA);
        chk("R7", "settle count", ceil_cyc(S_US), NS);

        run_seq(1'b0, -1);
        // R9: ready holds with no start
        repeat (10 + ($urandom % 20)) begin
            @(negedge clk);
            chk("R9", "ready held", bus_ready, 1);
        end
        // R9 + R8: restart from ready with ignored pulses mid-run
        run_seq(1'b1, -1);
        // R1: reset in the middle of a sequence
        run_seq(1'b0, 100 + int'($urandom % 200));
        repeat (4) begin
            @(negedge clk);
            check_idle("R1");
        end
        run_seq(1'b1, -1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule